// File: doc/BRIEF.md
# Power-Up Delay Sequencer

This block brings a processor core out of power-on reset. It runs on the internal RC oscillator clock. It waits until the supply has passed the power-on threshold and the external reset pin has been released. It then counts a fixed number of oscillator cycles and applies a short warmup. Once the supply is above the rising run threshold, it lets the core go. At the moment of release it asks the core to load its program counter with a fixed utility-ROM start vector. It also tells the clock block to adopt its power-up defaults: the RC source is selected and reported as the active clock.

The supply comparators are seen as plain digital inputs. If the supply drops or the external reset is asserted again at any point, the sequence returns to its idle state and later restarts from a zero count. After a stop-mode wake only the warmup part of the sequence runs again: the core clock comes back, but the start vector is not loaded a second time.

Top module: `pwrup_seq`

## Requirements
- R1: While `por_n` is low, `seq_done`, `core_clk_en`, `pc_load` and `dflt_load` are all 0.
- R2: Counting starts only when `supply_ok` and `ext_rst_n` are both 1. With only one of them high, no default load and no release ever occur.
- R3: The power-up count lasts exactly `PUP_CYCLES` clock cycles. It is followed by a single-cycle `dflt_load` pulse one edge after `start_ok` was first seen, plus `PUP_CYCLES` edges. During that pulse `dflt_sel_xt` is 0 (RC source) and `dflt_rc_active` is 1.
- R4: After the count, a warmup of exactly `WARM_CYCLES` (default 4) cycles runs before release is possible.
- R5: Release happens only while `supply_run` is 1. The sequencer waits after the warmup for as long as `supply_run` stays 0, and releases on the first edge at which it is 1.
- R6: On release, `seq_done`, `core_clk_en` and a single-cycle `pc_load` all rise together, with `start_addr` = 16'h8000. When all inputs are good from the start, this is `PUP_CYCLES + WARM_CYCLES + 2` edges after counting was enabled.
- R7: A low `supply_ok` or a low `ext_rst_n` in any state clears `seq_done` and `core_clk_en` at the next edge. When both are high again, a full sequence with a zero count restarts.
- R8: `seq_done` stays 1 from release until the next abort or power-on reset, including through stop mode.
- R9: `stop_req` while running drops `core_clk_en` at the next edge. A later `wake` runs only the `WARM_CYCLES` warmup, so `core_clk_en` returns `WARM_CYCLES + 2` edges after the wake edge, with no further `pc_load` or `dflt_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_rc | input | 1 | Internal RC oscillator clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| supply_ok | input | 1 | Supply above power-on threshold |
| ext_rst_n | input | 1 | External reset pin, active low |
| supply_run | input | 1 | Supply above rising run threshold |
| stop_req | input | 1 | Core enters stop mode |
| wake | input | 1 | Stop-mode exit request |
| seq_done | output | 1 | Core reset released; held until abort |
| core_clk_en | output | 1 | Core clock running |
| pc_load | output | 1 | One-cycle program counter load strobe |
| start_addr | output | ADDR_W | Start vector (16'h8000) |
| dflt_load | output | 1 | One-cycle strobe to load clock defaults |
| dflt_sel_xt | output | 1 | Default source select (0 = RC) |
| dflt_rc_active | output | 1 | Default status: RC is clock (1) |

## Verification
The assertions assume that `por_n` is held low for at least one edge before any check applies. They also assume that the supply and reset inputs change synchronously to the RC clock, since they are already filtered comparator outputs. The count-length and warmup-length properties depend on the enable running uninterrupted from zero, so the checker tracks run lengths with its own counters rather than deep history. The stimulus drives every input just after a rising edge. It holds reset for several cycles, and it never raises `stop_req` and `wake` in the same cycle. It also clears `stop_req` before a wake, so that the return to running is not immediately re-stopped.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COUNT,
    ST_WARM,
    ST_HOLD,
    ST_RUN,
    ST_STOP
  } seq_state_t;

  // Both supply above power-on level and external reset released.
  function automatic logic start_allowed(input logic sup_ok, input logic pin_rst_n);
    return sup_ok & pin_rst_n;
  endfunction

  // Edges from first start_ok edge to release with all inputs good.
  function automatic int unsigned release_latency(input int unsigned pup,
                                                  input int unsigned warm);
    return pup + warm + 2;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/cycle_counter.sv
module cycle_counter #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic arst_n,
  input  logic en,
  output logic last
);
  localparam int unsigned W = pwrup_pkg::cnt_width(LIMIT);
  localparam logic [W-1:0] LAST_VAL = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign last = en && (cnt == LAST_VAL);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)    cnt <= '0;
    else if (!en)   cnt <= '0;
    else if (last)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pwrup_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       start_ok,
  input  logic       supply_run,
  input  logic       stop_req,
  input  logic       wake,
  input  logic       pup_last,
  input  logic       warm_last,
  output seq_state_t state,
  output logic       released,
  output logic       ev_release,
  output logic       pup_en,
  output logic       warm_en
);
  seq_state_t nxt;

  assign pup_en     = start_ok && (state == ST_COUNT);
  assign warm_en    = start_ok && (state == ST_WARM);
  assign ev_release = start_ok && (state == ST_HOLD) && supply_run;

  always_comb begin
    nxt = state;
    if (!start_ok) begin
      nxt = ST_IDLE;
    end else begin
      case (state)
        ST_IDLE:  nxt = ST_COUNT;
        ST_COUNT: if (pup_last)   nxt = ST_WARM;
        ST_WARM:  if (warm_last)  nxt = ST_HOLD;
        ST_HOLD:  if (supply_run) nxt = ST_RUN;
        ST_RUN:   if (stop_req)   nxt = ST_STOP;
        ST_STOP:  if (wake)       nxt = ST_WARM;
        default:  nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state    <= ST_IDLE;
      released <= 1'b0;
    end else begin
      state <= nxt;
      if (!start_ok)       released <= 1'b0;
      else if (ev_release) released <= 1'b1;
    end
  end
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int unsigned    PUP_CYCLES  = 65536,
  parameter int unsigned    WARM_CYCLES = 4,
  parameter int unsigned    ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] START_ADDR = 16'h8000
) (
  input  logic              clk_rc,
  input  logic              por_n,
  input  logic              supply_ok,
  input  logic              ext_rst_n,
  input  logic              supply_run,
  input  logic              stop_req,
  input  logic              wake,
  output logic              seq_done,
  output logic              core_clk_en,
  output logic              pc_load,
  output logic [ADDR_W-1:0] start_addr,
  output logic              dflt_load,
  output logic              dflt_sel_xt,
  output logic              dflt_rc_active
);
  // Named internal events, visible to the bound checker.
  logic       start_ok;
  logic       pup_en, pup_last;
  logic       warm_en, warm_last;
  logic       ev_release;
  logic       released;
  seq_state_t state;
  logic       pc_load_q, dflt_load_q;

  assign start_ok = start_allowed(supply_ok, ext_rst_n);

  cycle_counter #(.LIMIT(PUP_CYCLES)) u_pup_cnt (
    .clk(clk_rc), .arst_n(por_n), .en(pup_en), .last(pup_last)
  );

  cycle_counter #(.LIMIT(WARM_CYCLES)) u_warm_cnt (
    .clk(clk_rc), .arst_n(por_n), .en(warm_en), .last(warm_last)
  );

  seq_fsm u_fsm (
    .clk(clk_rc), .arst_n(por_n), .start_ok(start_ok),
    .supply_run(supply_run), .stop_req(stop_req), .wake(wake),
    .pup_last(pup_last), .warm_last(warm_last),
    .state(state), .released(released), .ev_release(ev_release),
    .pup_en(pup_en), .warm_en(warm_en)
  );

  always_ff @(posedge clk_rc or negedge por_n) begin
    if (!por_n) begin
      pc_load_q   <= 1'b0;
      dflt_load_q <= 1'b0;
    end else begin
      pc_load_q   <= ev_release && !released;
      dflt_load_q <= pup_last;
    end
  end

  assign seq_done       = released;
  assign core_clk_en    = (state == ST_RUN);
  assign pc_load        = pc_load_q;
  assign start_addr     = START_ADDR;
  assign dflt_load      = dflt_load_q;
  assign dflt_sel_xt    = 1'b0;
  assign dflt_rc_active = 1'b1;
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
  parameter int unsigned PUP  = 65536,
  parameter int unsigned WARM = 4
) (
  input logic clk,
  input logic arst_n,
  input logic start_ok,
  input logic supply_run,
  input logic seq_done,
  input logic core_clk_en,
  input logic pc_load,
  input logic dflt_load,
  input logic pup_en,
  input logic pup_last,
  input logic warm_en,
  input logic warm_last
);
  logic [31:0] pup_len, warm_len;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pup_len  <= '0;
      warm_len <= '0;
    end else begin
      pup_len  <= pup_en  ? pup_len + 1  : '0;
      warm_len <= warm_en ? warm_len + 1 : '0;
    end
  end

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!arst_n)
    !start_ok |=> (!seq_done && !core_clk_en && !pc_load)); // R7
  AST_PUP_LENGTH: assert property (@(posedge clk) disable iff (!arst_n)
    pup_last |-> (pup_len == PUP - 1)); // R3
  AST_DFLT_AFTER_COUNT: assert property (@(posedge clk) disable iff (!arst_n)
    pup_last |=> dflt_load); // R3
  AST_WARM_LENGTH: assert property (@(posedge clk) disable iff (!arst_n)
    warm_last |-> (warm_len == WARM - 1)); // R4
  AST_RUN_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(core_clk_en) |-> $past(supply_run)); // R5
  AST_PCLOAD_SINGLE: assert property (@(posedge clk) disable iff (!arst_n)
    pc_load |=> !pc_load); // R6
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!arst_n)
    (seq_done && start_ok) |=> seq_done); // R8
  AST_PCLOAD_FIRST_ONLY: assert property (@(posedge clk) disable iff (!arst_n)
    pc_load |-> !$past(seq_done)); // R9
endmodule

bind pwrup_seq pwrup_seq_chk #(.PUP(PUP_CYCLES), .WARM(WARM_CYCLES)) u_chk (
  .clk(clk_rc), .arst_n(por_n), .start_ok(start_ok), .supply_run(supply_run),
  .seq_done(seq_done), .core_clk_en(core_clk_en), .pc_load(pc_load),
  .dflt_load(dflt_load), .pup_en(pup_en), .pup_last(pup_last),
  .warm_en(warm_en), .warm_last(warm_last)
);

// File: tb/pwrup_seq_test.sv
`timescale 1ns/1ps
module pwrup_seq_test;
  localparam int PUP  = 20;
  localparam int WARM = 4;
  localparam int LAT  = PUP + WARM + 2;

  logic clk = 1'b0;
  logic por_n, supply_ok, ext_rst_n, supply_run, stop_req, wake;
  logic seq_done, core_clk_en, pc_load, dflt_load, dflt_sel_xt, dflt_rc_active;
  logic [15:0] start_addr;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwrup_seq #(.PUP_CYCLES(PUP), .WARM_CYCLES(WARM)) uut (
    .clk_rc(clk), .por_n(por_n), .supply_ok(supply_ok), .ext_rst_n(ext_rst_n),
    .supply_run(supply_run), .stop_req(stop_req), .wake(wake),
    .seq_done(seq_done), .core_clk_en(core_clk_en), .pc_load(pc_load),
    .start_addr(start_addr), .dflt_load(dflt_load), .dflt_sel_xt(dflt_sel_xt),
    .dflt_rc_active(dflt_rc_active)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Drop to idle by pulling external reset for one edge.
  task automatic go_idle();
    ext_rst_n = 1'b0; stop_req = 1'b0; wake = 1'b0;
    step(1);
    ext_rst_n = 1'b1;
  endtask

  // Count edges until seq_done, noting dflt_load and pc_load edges.
  task automatic measure(output int kd, output int kdf, output int kpc);
    kd = 0; kdf = 0; kpc = 0;
    for (int k = 1; k <= 4 * LAT; k++) begin
      step(1);
      if (dflt_load && kdf == 0) kdf = k;
      if (pc_load && kpc == 0) kpc = k;
      if (seq_done) begin kd = k; break; end
    end
  endtask

  task automatic t_reset();
    chk(seq_done == 0 && core_clk_en == 0, "R1 done/clk_en in reset", seq_done, 0);
    chk(pc_load == 0 && dflt_load == 0, "R1 strobes in reset", pc_load, 0);
  endtask

  task automatic t_gating();
    int seen = 0;
    supply_ok = 1'b1; ext_rst_n = 1'b0; supply_run = 1'b1;
    for (int k = 0; k < 2 * LAT; k++) begin step(1); seen += dflt_load + seq_done; end
    chk(seen == 0, "R2 ext reset held", seen, 0);
    supply_ok = 1'b0; ext_rst_n = 1'b1;
    for (int k = 0; k < 2 * LAT; k++) begin step(1); seen += dflt_load + seq_done; end
    chk(seen == 0, "R2 supply low", seen, 0);
  endtask

  task automatic t_release();
    int kd, kdf, kpc;
    supply_ok = 1'b1; ext_rst_n = 1'b1; supply_run = 1'b1;
    measure(kd, kdf, kpc);
    chk(kdf == PUP + 1, "R3 default load edge", kdf, PUP + 1);
    chk(kd == LAT, "R4 R6 release latency", kd, LAT);
    chk(kpc == LAT, "R6 pc_load edge", kpc, LAT);
    chk(core_clk_en == 1, "R6 clock enabled", core_clk_en, 1);
    chk(start_addr == 16'h8000, "R6 start vector", start_addr, 16'h8000);
    chk(dflt_sel_xt == 0 && dflt_rc_active == 1, "R3 default values",
        {dflt_sel_xt, dflt_rc_active}, 1);
    step(1);
    chk(pc_load == 0, "R6 pc_load single cycle", pc_load, 0);
  endtask

  task automatic t_hold();
    go_idle();
    supply_run = 1'b0;
    step(LAT + 10);
    chk(seq_done == 0 && core_clk_en == 0, "R5 held without run supply", seq_done, 0);
    supply_run = 1'b1;
    step(1);
    chk(seq_done == 1 && pc_load == 1, "R5 release on run supply", seq_done, 1);
  endtask

  task automatic t_abort();
    int kd, kdf, kpc;
    go_idle();
    step(10);
    ext_rst_n = 1'b0;
    step(1);
    chk(seq_done == 0, "R7 abort mid-count", seq_done, 0);
    ext_rst_n = 1'b1;
    measure(kd, kdf, kpc);
    chk(kd == LAT, "R7 restart from zero", kd, LAT);
    supply_ok = 1'b0;
    step(1);
    chk(seq_done == 0 && core_clk_en == 0, "R7 abort after release", core_clk_en, 0);
    supply_ok = 1'b1;
    measure(kd, kdf, kpc);
    chk(kd == LAT, "R7 second restart", kd, LAT);
  endtask

  task automatic t_stop();
    int kc = 0;
    int strobes = 0;
    stop_req = 1'b1;
    step(1);
    stop_req = 1'b0;
    chk(core_clk_en == 0, "R9 stop clears clock", core_clk_en, 0);
    step(30);
    chk(seq_done == 1, "R8 done held in stop", seq_done, 1);
    wake = 1'b1;
    for (int k = 1; k <= 40; k++) begin
      step(1);
      wake = 1'b0;
      strobes += pc_load + dflt_load;
      if (core_clk_en) begin kc = k; break; end
    end
    chk(kc == WARM + 2, "R9 wake warmup latency", kc, WARM + 2);
    chk(strobes == 0, "R9 no reload on wake", strobes, 0);
    step(50);
    chk(seq_done == 1, "R8 done held long", seq_done, 1);
  endtask

  initial begin
    por_n = 1'b0; supply_ok = 1'b0; ext_rst_n = 1'b0; supply_run = 1'b0;
    stop_req = 1'b0; wake = 1'b0;
    step(3);
    t_reset();
    por_n = 1'b1;
    t_gating();
    t_release();
    t_stop();
    t_hold();
    t_abort();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule